// File: doc/BRIEF.md
# Register-Bank I2C Slave

This block lets an I2C or SMBus master read and write a bank of byte-wide internal registers. SCL arrives on an input-only pin. SDA is split into a sampled input and an open-drain pull-down output (`sda_pull_o` high means "drive the line low"). The two can be joined outside the block to form an ordinary bidirectional SDA line. Both bus lines are synchronised into the system clock domain, which must run at least eight times faster than SCL. START, repeated START and STOP are all detected there.

A transfer begins with an address byte. The upper seven bits of that byte are the slave address and bit 0 is the direction. In a write, the first byte after the address is a command, and its low six bits set an internal register pointer. Each later data byte is stored at the pointer, and the pointer then advances by one. A read uses a repeated START and the address with the direction bit set. The slave then streams bytes from the pointer for as long as the master acknowledges. The pointer wraps from the last register back to zero, and every STOP returns it to zero. A watchdog releases the bus if either line stays low for too long.

There is no streaming interface at the block's edge. All pins are plain control or bus pins, so no back-pressure rules apply.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal {3'b110, dev_addr_i}. It acknowledges by holding `sda_pull_o` high through the 9th SCL clock of that byte. The direction bit is bit 0 of the byte, with 0 meaning write and 1 meaning read.
- R2: An address byte of 7'b1100110 with the write direction is acknowledged and accepted whatever `dev_addr_i` is. The same address with the read direction is not acknowledged unless it also equals the slave's own address.
- R3: After an address that matches neither case, and while idle, the slave never asserts `sda_pull_o` until the next START.
- R4: The byte after a write-direction address is a command. It is acknowledged, and only its bits [5:0] are loaded into the register pointer; bits [7:6] are ignored.
- R5: Every data byte written after the command is acknowledged and stored at the pointer. Every data byte written or read advances the pointer by one. After register 43h (REG_COUNT-1) the pointer wraps to 00h.
- R6: A STOP ends the transfer and sets the pointer to 00h.
- R7: In a read, each byte is sent MSB first. Bit 7 is already on the line when the first SCL rise of that byte occurs.
- R8: After the master leaves a read byte unacknowledged, the slave releases SDA and ignores further clocks until the next START.
- R9: A START received at any point, including in the middle of a byte, restarts address reception. A repeated START keeps the pointer.
- R10: If SCL or SDA stays low for WDOG_LIMIT system cycles, the slave releases SDA and goes idle. It then resumes normal operation at the next START.
- R11: The slave changes `sda_pull_o` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr_i | input | 4 | Low four bits of the slave address |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release |

## Verification
The bench builds the block with REG_COUNT at its default of 68. This keeps the 3Fh-to-43h-to-00h wrap inside a six-byte burst. WDOG_LIMIT is reduced to 600 system cycles so that a stalled acknowledge can outlast the watchdog in a short test. The limit is still well above the longest low stretch that normal traffic at a 20-cycle SCL period produces. SYNC_STAGES stays at 2, which fixes the delay from each SCL edge to the slave's response at three system cycles, well inside a quarter SCL period.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WR,
    ST_RD,
    ST_MACK
  } slv_state_e;

  localparam logic [2:0] DEV_PREFIX = 3'b110;
  localparam logic [6:0] BCAST_ADDR = 7'b1100110;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // Line conditions: SDA moves while SCL is high on both samples
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_stuck_wdog.sv
module i2c_stuck_wdog #(
  parameter int LIMIT = 3_300_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic timeout_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;
  logic          bus_low;

  assign bus_low = ~(scl_s & sda_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!bus_low)            cnt <= '0;
    else if (cnt != CW'(LIMIT))   cnt <= cnt + 1'b1;
  end

  // One pulse per stuck episode: the counter saturates past this value
  assign timeout_o = bus_low && (cnt == CW'(LIMIT - 1));

  // R10: a released bus restarts the window, so no timeout follows it
  p_wdog_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && sda_s) |=> !timeout_o);
endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file #(
  parameter int DEPTH = 68,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];

  // R5: the engine's pointer never addresses past the bank
  p_wr_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> (int'(waddr_i) < DEPTH));
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
  import i2c_slv_pkg::*;
#(
  parameter int REG_COUNT   = 68,          // must be at least 64
  parameter int WDOG_LIMIT  = 3_300_000,   // system cycles
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] dev_addr_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o
);
  localparam int               PTR_W    = $clog2(REG_COUNT);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(REG_COUNT - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, wd_to;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .scl_i, .sda_i,
    .scl_s, .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det
  );

  i2c_stuck_wdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
    .clk, .rst_n, .scl_s, .sda_s, .timeout_o(wd_to)
  );

  slv_state_e       state;
  logic [3:0]       cnt;
  logic [7:0]       rx_sr, tx_sr;
  logic [PTR_W-1:0] ptr, ptr_nxt, waddr;
  logic [7:0]       wdata, rd_data;
  logic             we, ack_on, pull, mack_ok;
  logic             own_hit, bc_hit;

  i2c_reg_file #(.DEPTH(REG_COUNT), .AW(PTR_W)) u_regs (
    .clk, .rst_n, .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(ptr), .rdata_o(rd_data)
  );

  assign ptr_nxt = (ptr == LAST_PTR) ? '0 : ptr + 1'b1;
  assign own_hit = (rx_sr[7:1] == {DEV_PREFIX, dev_addr_i});
  assign bc_hit  = (rx_sr[7:1] == BCAST_ADDR) && !rx_sr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      ptr     <= '0;
      waddr   <= '0;
      wdata   <= '0;
      we      <= 1'b0;
      ack_on  <= 1'b0;
      pull    <= 1'b0;
      mack_ok <= 1'b0;
    end else begin
      we <= 1'b0;
      if (wd_to || stop_det) begin
        state  <= ST_IDLE;
        pull   <= 1'b0;
        ack_on <= 1'b0;
        ptr    <= '0;
      end else if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        pull   <= 1'b0;
        ack_on <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_CMD, ST_WR: begin
            if (scl_rise && cnt < 4'd8) begin
              rx_sr <= {rx_sr[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && ack_on) begin
              // end of the acknowledge clock
              ack_on <= 1'b0;
              pull   <= 1'b0;
              cnt    <= '0;
              if (state == ST_ADDR) begin
                if (rx_sr[0]) begin
                  state <= ST_RD;
                  tx_sr <= rd_data;
                  pull  <= ~rd_data[7];
                end else begin
                  state <= ST_CMD;
                end
              end else begin
                state <= ST_WR;
              end
            end else if (scl_fall && cnt == 4'd8) begin
              if (state == ST_ADDR && !(own_hit || bc_hit)) begin
                state <= ST_IDLE;
              end else begin
                ack_on <= 1'b1;
                pull   <= 1'b1;
                if (state == ST_CMD) ptr <= PTR_W'(rx_sr[5:0]);
                if (state == ST_WR) begin
                  we    <= 1'b1;
                  waddr <= ptr;
                  wdata <= rx_sr;
                  ptr   <= ptr_nxt;
                end
              end
            end
          end
          ST_RD: begin
            if (scl_rise && cnt < 4'd8) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                pull  <= 1'b0;
                ptr   <= ptr_nxt;
                state <= ST_MACK;
              end else begin
                pull <= ~tx_sr[~cnt[2:0]];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_ok <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_ok) begin
                tx_sr <= rd_data;
                pull  <= ~rd_data[7];
                cnt   <= '0;
                state <= ST_RD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull;

  // R3: an idle engine leaves the line alone
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_pull_o);

  // R5: pointer stays inside the bank
  p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST_PTR);

  // R6: STOP returns the pointer to zero
  p_stop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (ptr == '0));

  // R10: a watchdog expiry releases SDA and idles the engine
  p_wdog_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wd_to |=> (!sda_pull_o && state == ST_IDLE));

  // R11: output moves only after SCL has gone low
  p_sda_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det) && !$past(wd_to))
      |-> $stable(sda_pull_o));
endmodule

// File: tb/tb_i2c_regbank_slave.sv
module tb_i2c_regbank_slave;
  localparam int Q    = 5;     // quarter SCL period in system cycles
  localparam int WDOG = 600;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [3:0] dev_addr = 4'h5;
  logic       sda_pull;
  logic       sda_line;

  int n_tests = 0;
  int n_fail  = 0;
  int r11_viol = 0;
  logic scl_q = 1'b1, pull_q = 1'b0;

  localparam logic [7:0] OWN_W = 8'hCA, OWN_R = 8'hCB;
  localparam logic [7:0] BC_W  = 8'hCC, BC_R  = 8'hCD;
  localparam logic [7:0] BAD_W = 8'hC2;

  assign sda_line = sda_m & ~sda_pull;

  always #5 clk = ~clk;

  i2c_regbank_slave #(.REG_COUNT(68), .WDOG_LIMIT(WDOG), .SYNC_STAGES(2)) dut (
    .clk, .rst_n, .dev_addr_i(dev_addr), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull)
  );

  // R11 monitor: the output must not move while SCL stays high
  always @(negedge clk) begin
    if (rst_n && scl_q && scl_m && (sda_pull != pull_q)) r11_viol++;
    scl_q  = scl_m;
    pull_q = sda_pull;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(2*Q);
    sda_m = 1'b0; hold(2*Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b1; hold(2*Q);
    sda_m = 1'b1; hold(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sda_m = b[i]; hold(Q);
      scl_m = 1'b1; hold(2*Q);
      scl_m = 1'b0; hold(Q);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    ack = ~sda_line;
    hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(Q);
      scl_m = 1'b1; hold(Q);
      b[i] = sda_line;
      hold(Q);
      scl_m = 1'b0;
    end
    hold(Q);
    sda_m = ~mack; hold(Q);
    scl_m = 1'b1; hold(2*Q);
    scl_m = 1'b0; hold(Q);
    sda_m = 1'b1;
  endtask

  // Point at cmd, then repeated START and read n bytes into the log
  logic [7:0] rd_log [8];
  task automatic read_from(input logic [7:0] cmd, input int n);
    logic a;
    bus_start();
    wr_byte(OWN_W, a);
    wr_byte(cmd, a);
    bus_start();
    wr_byte(OWN_R, a);
    for (int i = 0; i < n; i++) rd_byte(i != n - 1, rd_log[i]);
    bus_stop();
  endtask

  task automatic t_reset();
    check("R3 reset: sda_pull low", {7'b0, sda_pull}, 8'h00);
  endtask

  task automatic t_single_write_read();
    logic a0, a1, a2;
    bus_start();
    wr_byte(OWN_W, a0);
    wr_byte(8'h03, a1);
    wr_byte(8'hA5, a2);
    bus_stop();
    check("R1 own address acked", {7'b0, a0}, 8'h01);
    check("R4 command acked", {7'b0, a1}, 8'h01);
    check("R5 data acked", {7'b0, a2}, 8'h01);
    read_from(8'h03, 1);
    check("R7 single read MSB first", rd_log[0], 8'hA5);
  endtask

  task automatic t_burst_wrap();
    logic a;
    logic [7:0] pat [6] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    bus_start();
    wr_byte(OWN_W, a);
    wr_byte(8'h3F, a);
    for (int i = 0; i < 6; i++) wr_byte(pat[i], a);
    bus_stop();
    read_from(8'h3F, 6);
    for (int i = 0; i < 6; i++) check("R5 burst wrap 43h->00h", rd_log[i], pat[i]);
  endtask

  task automatic t_cmd_mask();
    logic a;
    bus_start();
    wr_byte(OWN_W, a);
    wr_byte(8'hC2, a);
    wr_byte(8'h5A, a);
    bus_stop();
    read_from(8'h02, 1);
    check("R4 command bits 7:6 ignored", rd_log[0], 8'h5A);
  endtask

  task automatic t_stop_clears();
    logic a;
    logic [7:0] b;
    bus_start();
    wr_byte(OWN_W, a);
    wr_byte(8'h10, a);
    wr_byte(8'h77, a);
    bus_stop();
    bus_start();
    wr_byte(OWN_R, a);
    rd_byte(1'b0, b);
    bus_stop();
    check("R6 pointer zero after STOP", b, 8'h66);
  endtask

  task automatic t_broadcast();
    logic a0, a1;
    bus_start();
    wr_byte(BC_W, a0);
    wr_byte(8'h20, a1);
    wr_byte(8'h3C, a1);
    bus_stop();
    check("R2 broadcast write acked", {7'b0, a0}, 8'h01);
    read_from(8'h20, 1);
    check("R2 broadcast data stored", rd_log[0], 8'h3C);
    bus_start();
    wr_byte(BC_R, a0);
    bus_stop();
    check("R2 broadcast read not acked", {7'b0, a0}, 8'h00);
  endtask

  task automatic t_mismatch();
    logic a0, a1;
    bus_start();
    wr_byte(BAD_W, a0);
    wr_byte(8'h00, a1);
    bus_stop();
    check("R3 foreign address not acked", {7'b0, a0}, 8'h00);
    check("R3 silent after foreign address", {7'b0, a1}, 8'h00);
  endtask

  task automatic t_restart();
    logic a;
    bus_start();
    send_bits(8'hB0, 4);
    bus_start();
    wr_byte(OWN_W, a);
    check("R9 START mid-byte restarts address", {7'b0, a}, 8'h01);
    wr_byte(8'h05, a);
    wr_byte(8'hC3, a);
    bus_stop();
    read_from(8'h05, 1);
    check("R9 restarted transfer stored", rd_log[0], 8'hC3);
  endtask

  task automatic t_master_nack();
    logic a;
    logic [7:0] b;
    bus_start();
    wr_byte(OWN_W, a);
    wr_byte(8'h03, a);
    bus_start();
    wr_byte(OWN_R, a);
    rd_byte(1'b0, b);
    check("R8 byte before NACK", b, 8'hA5);
    check("R8 SDA released after NACK", {7'b0, sda_pull}, 8'h00);
    rd_byte(1'b0, b);
    check("R8 clocks ignored after NACK", b, 8'hFF);
    bus_stop();
  endtask

  task automatic t_watchdog();
    logic a;
    bus_start();
    send_bits(OWN_W, 8);
    hold(Q);
    check("R1 ack pull during 9th clock", {7'b0, sda_pull}, 8'h01);
    hold(WDOG + 100);
    check("R10 SDA released by watchdog", {7'b0, sda_pull}, 8'h00);
    wr_byte(OWN_W, a);
    check("R10 idle until next START", {7'b0, a}, 8'h00);
    bus_stop();
    bus_start();
    wr_byte(OWN_W, a);
    wr_byte(8'h07, a);
    wr_byte(8'h9E, a);
    bus_stop();
    read_from(8'h07, 1);
    check("R10 normal operation after START", rd_log[0], 8'h9E);
  endtask

  initial begin
    hold(5);
    rst_n = 1'b1;
    hold(5);
    t_reset();
    t_single_write_read();
    t_burst_wrap();
    t_cmd_mask();
    t_stop_clears();
    t_broadcast();
    t_mismatch();
    t_restart();
    t_master_nack();
    t_watchdog();
    check("R11 no SDA change while SCL high", r11_viol[7:0], 8'h00);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule